// File: doc/BRIEF.md
# Halt Mode Wake Controller

This block sits next to a processor core and manages its low-power halt states. When the core executes a halt, the block latches a 2-bit mode and gates the clocks to match it. While halted, it examines incoming interrupt requests and decides whether each one releases the core. A released core is told, through single-cycle strobes, which sources to service and in what order. It may instead be told only to resume at the instruction after the halt.

Three request sources are handled. A maskable request is compared against a 3-bit mask. A non-maskable request always gets through. A special external-pin request always wakes the core but is serviced only when its level beats the mask. The stop and idle1 modes need a few cycles to shut down, so the block opens an entry window of `WIN_CYC` cycles for them. Requests seen during that window are held as pending and do not wake the core. Once entry is complete, a fresh request wakes the core. Everything held plus everything new is then drained one event per cycle, from the highest priority down.

Top module: `hwk_ctrl`

## Requirements
- R1: After reset the block is in run: core, peripheral and oscillator enables are 1, and `halted_o`, `enter_o`, `pend_o`, `wake_o`, `svc_o` and `resume_o` are 0.
- R2: A halt request with mode 00 leaves the block in run, with no clock gated and `halted_o` still 0.
- R3: The modes are encoded 01 = stop, 10 = idle1, 11 = idle2. From the first cycle after the halt request, the core clock is off in every halt mode. The peripheral clock is off in stop and idle1 only. The oscillator is off in stop only.
- R4: Stop and idle1 hold `enter_o` high for exactly `WIN_CYC` cycles before settling. Idle2 settles at once, with `enter_o` never set. `halted_o` is high throughout entry and the settled halt.
- R5: While settled, a maskable request whose level is strictly greater than the mask wakes the core. The next cycle shows `wake_o` = 1, `svc_o` = 1 and `svc_src_o` = 00.
- R6: A maskable request whose level is less than or equal to the mask does not wake the core.
- R7: A non-maskable request wakes the core and is serviced with `svc_src_o` = 10, whatever the mask.
- R8: A pin request always wakes the core. If its level is greater than the mask it is serviced with `svc_src_o` = 01. Otherwise `resume_o` pulses instead of `svc_o`. `svc_o` and `resume_o` are never high together.
- R9: During the entry window, a qualifying request sets `pend_o` and causes no wake.
- R10: After entry, a request from a source not already pending wakes the core. `wake_o` pulses in the first drain cycle only. Held and new sources then produce one event per cycle in the order non-maskable, pin, maskable.
- R11: A halt request is ignored unless the block is in run, and interrupt requests have no effect while in run.
- R12: After the last drain event the block is back in run, with all clocks enabled and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Core executes a halt this cycle |
| mode_i | input | 2 | Halt mode: 00 run, 01 stop, 10 idle1, 11 idle2 |
| mask_i | input | 3 | Current interrupt mask level |
| mi_req | input | 1 | Maskable request present |
| mi_lvl | input | 3 | Level of the maskable request |
| pin_req | input | 1 | Special external-pin request present |
| pin_lvl | input | 3 | Level of the pin request |
| nmi_req | input | 1 | Non-maskable request present |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| halted_o | output | 1 | Entering or in a halt state |
| enter_o | output | 1 | Entry window in progress |
| pend_o | output | 1 | A request is held while halted |
| wake_o | output | 1 | Wake strobe, first drain cycle |
| svc_o | output | 1 | Service strobe for `svc_src_o` |
| svc_src_o | output | 2 | Serviced source: 00 maskable, 01 pin, 10 non-maskable |
| resume_o | output | 1 | Pin woke the core without service |

## Verification
A wrong state or mode register shows up on the three clock enables one cycle after the halt request, and on `halted_o` or `enter_o` at the cycle where the window should close. A corrupted held-request set is visible on `pend_o` at once. It also shows up in the drain sequence: a missing, duplicated or misordered event appears within the cycles that follow the wake. A lost pin-service flag makes `resume_o` and `svc_o` swap in the pin's drain cycle.

// File: rtl/hwk_pkg.sv
package hwk_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_HALT  = 2'd2,
        ST_DRAIN = 2'd3
    } hwk_state_e;

    typedef enum logic [1:0] {
        MD_RUN   = 2'b00,
        MD_STOP  = 2'b01,
        MD_IDLE1 = 2'b10,
        MD_IDLE2 = 2'b11
    } hwk_mode_e;

    // source index doubles as priority: higher index wins
    localparam int SRC_N   = 3;
    localparam int SRC_W   = 2;
    localparam int SRC_MI  = 0;
    localparam int SRC_PIN = 1;
    localparam int SRC_NMI = 2;

endpackage

// File: rtl/hwk_qualify.sv
module hwk_qualify
    import hwk_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             mi_req,
    input  logic [LVL_W-1:0] mi_lvl,
    input  logic             pin_req,
    input  logic [LVL_W-1:0] pin_lvl,
    input  logic             nmi_req,
    input  logic [LVL_W-1:0] mask_i,
    output logic [SRC_N-1:0] live,
    output logic             pin_svc
);
    always_comb begin
        live          = '0;
        // equal level counts as masked
        live[SRC_MI]  = mi_req && (mi_lvl > mask_i);
        live[SRC_PIN] = pin_req;
        live[SRC_NMI] = nmi_req;
        pin_svc       = pin_req && (pin_lvl > mask_i);
    end
endmodule

// File: rtl/hwk_pick.sv
module hwk_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = |req;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hwk_gate.sv
module hwk_gate
    import hwk_pkg::*;
(
    input  hwk_state_e st,
    input  hwk_mode_e  mode,
    output logic       core_en,
    output logic       periph_en,
    output logic       osc_en
);
    logic gated;
    always_comb begin
        gated     = (st == ST_ENTER) || (st == ST_HALT);
        core_en   = !gated;
        periph_en = !(gated && ((mode == MD_STOP) || (mode == MD_IDLE1)));
        osc_en    = !(gated && (mode == MD_STOP));
    end
endmodule

// File: rtl/hwk_ctrl.sv
module hwk_ctrl
    import hwk_pkg::*;
#(
    parameter int WIN_CYC = 3,
    parameter int LVL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic [1:0]       mode_i,
    input  logic [LVL_W-1:0] mask_i,
    input  logic             mi_req,
    input  logic [LVL_W-1:0] mi_lvl,
    input  logic             pin_req,
    input  logic [LVL_W-1:0] pin_lvl,
    input  logic             nmi_req,
    output logic             core_clk_en_o,
    output logic             periph_clk_en_o,
    output logic             osc_en_o,
    output logic             halted_o,
    output logic             enter_o,
    output logic             pend_o,
    output logic             wake_o,
    output logic             svc_o,
    output logic [SRC_W-1:0] svc_src_o,
    output logic             resume_o
);
    localparam int CW = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIN_CYC - 1);

    typedef struct packed {
        hwk_state_e       st;
        hwk_mode_e        mode;
        logic [CW-1:0]    cnt;
        logic [SRC_N-1:0] set;
        logic             psvc;
        logic             first;
    } hwk_regs_t;

    hwk_regs_t q, d;

    logic [SRC_N-1:0] live;
    logic             pin_svc;
    logic [SRC_N-1:0] gnt;
    logic [SRC_W-1:0] top;
    logic             any;
    logic             pin_plain;

    hwk_qualify #(.LVL_W(LVL_W)) u_qual (
        .mi_req (mi_req),
        .mi_lvl (mi_lvl),
        .pin_req(pin_req),
        .pin_lvl(pin_lvl),
        .nmi_req(nmi_req),
        .mask_i (mask_i),
        .live   (live),
        .pin_svc(pin_svc)
    );

    hwk_pick #(.N(SRC_N), .IW(SRC_W)) u_pick (
        .req(q.set),
        .gnt(gnt),
        .idx(top),
        .any(any)
    );

    hwk_gate u_gate (
        .st       (q.st),
        .mode     (q.mode),
        .core_en  (core_clk_en_o),
        .periph_en(periph_clk_en_o),
        .osc_en   (osc_en_o)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_RUN: begin
                if (halt_req && (mode_i != MD_RUN)) begin
                    d.set   = '0;
                    d.psvc  = 1'b0;
                    d.cnt   = '0;
                    d.first = 1'b0;
                    d.mode  = hwk_mode_e'(mode_i);
                    // idle2 needs no shutdown window
                    d.st    = (mode_i == MD_IDLE2) ? ST_HALT : ST_ENTER;
                end
            end
            ST_ENTER: begin
                d.set  = q.set | live;
                d.psvc = q.psvc | pin_svc;
                if (q.cnt == CNT_LAST) begin
                    d.st = ST_HALT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HALT: begin
                // only a source not already held can release the core
                if (|(live & ~q.set)) begin
                    d.st    = ST_DRAIN;
                    d.set   = q.set | live;
                    d.psvc  = q.psvc | pin_svc;
                    d.first = 1'b1;
                end
            end
            ST_DRAIN: begin
                d.first = 1'b0;
                d.set   = q.set & ~gnt;
                if ((q.set & ~gnt) == '0) begin
                    d.st   = ST_RUN;
                    d.psvc = 1'b0;
                    d.mode = MD_RUN;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, mode: MD_RUN, cnt: '0, set: '0, psvc: 1'b0, first: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        halted_o  = (q.st == ST_ENTER) || (q.st == ST_HALT);
        enter_o   = (q.st == ST_ENTER);
        pend_o    = halted_o && (|q.set);
        wake_o    = (q.st == ST_DRAIN) && q.first;
        pin_plain = (top == SRC_W'(SRC_PIN)) && !q.psvc;
        resume_o  = (q.st == ST_DRAIN) && any && pin_plain;
        svc_o     = (q.st == ST_DRAIN) && any && !pin_plain;
        svc_src_o = svc_o ? top : '0;
    end

endmodule

// File: rtl/hwk_ctrl_chk.sv
module hwk_ctrl_chk #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_req,
    input logic [1:0]       mode_i,
    input logic [LVL_W-1:0] mask_i,
    input logic             mi_req,
    input logic [LVL_W-1:0] mi_lvl,
    input logic             pin_req,
    input logic             nmi_req,
    input logic             core_clk_en_o,
    input logic             osc_en_o,
    input logic             halted_o,
    input logic             enter_o,
    input logic             pend_o,
    input logic             wake_o,
    input logic             svc_o,
    input logic             resume_o
);
    p_wake_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    p_svc_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_o && resume_o));

    p_nmi_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !enter_o && !pend_o && nmi_req) |=> (wake_o && svc_o));

    p_masked_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !enter_o && !nmi_req && !pin_req && (!mi_req || mi_lvl <= mask_i))
        |=> !wake_o);

    p_window_nowake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |=> !wake_o);

    p_mode_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && !svc_o && !resume_o && halt_req && mode_i == 2'b00)
        |=> (core_clk_en_o && !halted_o));

    p_osc_off_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> halted_o);
endmodule

bind hwk_ctrl hwk_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .mode_i       (mode_i),
    .mask_i       (mask_i),
    .mi_req       (mi_req),
    .mi_lvl       (mi_lvl),
    .pin_req      (pin_req),
    .nmi_req      (nmi_req),
    .core_clk_en_o(core_clk_en_o),
    .osc_en_o     (osc_en_o),
    .halted_o     (halted_o),
    .enter_o      (enter_o),
    .pend_o       (pend_o),
    .wake_o       (wake_o),
    .svc_o        (svc_o),
    .resume_o     (resume_o)
);

// File: tb/sim_hwk_ctrl.sv
module sim_hwk_ctrl;
    localparam int CLK_PER = 10;
    localparam int WIN     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic [2:0] mask_i = 3'd0;
    logic       mi_req = 1'b0;
    logic [2:0] mi_lvl = 3'd0;
    logic       pin_req = 1'b0;
    logic [2:0] pin_lvl = 3'd0;
    logic       nmi_req = 1'b0;
    logic       core_clk_en_o, periph_clk_en_o, osc_en_o, halted_o, enter_o;
    logic       pend_o, wake_o, svc_o, resume_o;
    logic [1:0] svc_src_o;

    int errors = 0;
    int checks = 0;

    // bench-side expectation state
    logic [1:0] m_st = 2'd0;   // 0 run, 1 entering, 2 halted, 3 draining
    logic [1:0] m_mode = 2'd0;
    int         m_cnt = 0;
    logic [2:0] m_set = 3'd0;
    logic       m_psvc = 1'b0;
    logic       m_first = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    hwk_ctrl #(.WIN_CYC(WIN), .LVL_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .mode_i(mode_i),
        .mask_i(mask_i), .mi_req(mi_req), .mi_lvl(mi_lvl), .pin_req(pin_req),
        .pin_lvl(pin_lvl), .nmi_req(nmi_req), .core_clk_en_o(core_clk_en_o),
        .periph_clk_en_o(periph_clk_en_o), .osc_en_o(osc_en_o),
        .halted_o(halted_o), .enter_o(enter_o), .pend_o(pend_o),
        .wake_o(wake_o), .svc_o(svc_o), .svc_src_o(svc_src_o),
        .resume_o(resume_o)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] top_of(input logic [2:0] s);
        if (s[2]) return 2'd2;
        if (s[1]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic compare_all();
        logic gated, e_res, e_svc;
        logic [1:0] t;
        gated = (m_st == 2'd1) || (m_st == 2'd2);
        t     = top_of(m_set);
        e_res = (m_st == 2'd3) && (t == 2'd1) && !m_psvc;
        e_svc = (m_st == 2'd3) && !e_res;
        chk("R3 core", {3'b0, core_clk_en_o}, {3'b0, !gated});
        chk("R3 periph", {3'b0, periph_clk_en_o}, {3'b0, !(gated && (m_mode == 2'd1 || m_mode == 2'd2))});
        chk("R3 osc", {3'b0, osc_en_o}, {3'b0, !(gated && m_mode == 2'd1)});
        chk("R4 halted", {3'b0, halted_o}, {3'b0, gated});
        chk("R4 enter", {3'b0, enter_o}, {3'b0, m_st == 2'd1});
        chk("R9 pend", {3'b0, pend_o}, {3'b0, gated && (|m_set)});
        chk("R10 wake", {3'b0, wake_o}, {3'b0, (m_st == 2'd3) && m_first});
        chk("R5 svc", {3'b0, svc_o}, {3'b0, e_svc});
        chk("R5 src", {2'b0, svc_src_o}, {2'b0, e_svc ? t : 2'd0});
        chk("R8 resume", {3'b0, resume_o}, {3'b0, e_res});
    endtask

    // one clock: expectation from requirements, edge, then compare
    task automatic step();
        logic [1:0] ns; logic [1:0] nmode; int ncnt; logic [2:0] nset;
        logic npsvc, nfirst; logic [2:0] live; logic psv; logic [2:0] g;
        ns = m_st; nmode = m_mode; ncnt = m_cnt; nset = m_set; npsvc = m_psvc; nfirst = m_first;
        live  = {nmi_req, pin_req, mi_req && (mi_lvl > mask_i)};
        psv   = pin_req && (pin_lvl > mask_i);
        case (m_st)
            2'd0: if (halt_req && mode_i != 2'b00) begin
                nset = 0; npsvc = 0; ncnt = 0; nfirst = 0; nmode = mode_i;
                ns = (mode_i == 2'b11) ? 2'd2 : 2'd1;
            end
            2'd1: begin
                nset = m_set | live; npsvc = m_psvc | psv;
                if (m_cnt == WIN - 1) ns = 2'd2; else ncnt = m_cnt + 1;
            end
            2'd2: if (|(live & ~m_set)) begin
                ns = 2'd3; nset = m_set | live; npsvc = m_psvc | psv; nfirst = 1;
            end
            default: begin
                g = 3'b001 << top_of(m_set);
                nfirst = 0; nset = m_set & ~g;
                if (nset == 0) begin ns = 2'd0; npsvc = 0; nmode = 2'd0; end
            end
        endcase
        @(posedge clk);
        #1;
        m_st = ns; m_mode = nmode; m_cnt = ncnt; m_set = nset; m_psvc = npsvc; m_first = nfirst;
        compare_all();
    endtask

    task automatic idle_in();
        halt_req = 0; mi_req = 0; pin_req = 0; nmi_req = 0;
    endtask

    initial begin
        #(CLK_PER * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #(CLK_PER/2);
        // R1 reset state
        chk("R1 core", {3'b0, core_clk_en_o}, 4'd1);
        chk("R1 periph", {3'b0, periph_clk_en_o}, 4'd1);
        chk("R1 osc", {3'b0, osc_en_o}, 4'd1);
        chk("R1 halted", {3'b0, halted_o}, 4'd0);
        chk("R1 pend", {3'b0, pend_o}, 4'd0);
        chk("R1 strobes", {1'b0, wake_o, svc_o, resume_o}, 4'd0);

        // R11: requests in run do nothing
        nmi_req = 1; mi_req = 1; mi_lvl = 7; step(); idle_in();
        chk("R11 run ignores req", {3'b0, wake_o}, 4'd0);

        // R2: mode 00 halt is a no-op
        halt_req = 1; mode_i = 2'b00; step(); idle_in();
        chk("R2 halted", {3'b0, halted_o}, 4'd0);
        chk("R2 core", {3'b0, core_clk_en_o}, 4'd1);

        // stop mode, mask 3
        mask_i = 3; halt_req = 1; mode_i = 2'b01; step(); idle_in();
        chk("R3 stop gating", {1'b0, core_clk_en_o, periph_clk_en_o, osc_en_o}, 4'd0);
        for (int i = 0; i < WIN - 1; i++) begin
            step();
            chk("R4 still entering", {3'b0, enter_o}, 4'd1);
        end
        step();
        chk("R4 settled", {2'b0, halted_o, enter_o}, 4'b0010);
        mi_req = 1; mi_lvl = 3; step();
        chk("R6 equal level", {3'b0, wake_o}, 4'd0);
        mi_lvl = 1; step();
        chk("R6 lower level", {3'b0, wake_o}, 4'd0);
        mi_lvl = 5; step(); idle_in();
        chk("R5 wake", {3'b0, wake_o}, 4'd1);
        chk("R5 svc src", {1'b0, svc_o, svc_src_o}, 4'b0100);
        step();
        chk("R12 back to run", {svc_o, halted_o, core_clk_en_o, osc_en_o}, 4'b0011);

        // idle1, pin held during window, then nmi
        mask_i = 6; halt_req = 1; mode_i = 2'b10; step(); idle_in();
        chk("R3 idle1 gating", {1'b0, core_clk_en_o, periph_clk_en_o, osc_en_o}, 4'b0001);
        pin_req = 1; pin_lvl = 2; step(); idle_in();
        chk("R9 pending", {2'b0, pend_o, wake_o}, 4'b0010);
        while (enter_o) step();
        step();
        chk("R9 held not waking", {2'b0, pend_o, wake_o}, 4'b0010);
        nmi_req = 1; step(); idle_in();
        chk("R10 wake first", {3'b0, wake_o}, 4'd1);
        chk("R7 nmi first", {1'b0, svc_o, svc_src_o}, 4'b0110);
        step();
        chk("R10 single wake", {3'b0, wake_o}, 4'd0);
        chk("R8 resume not svc", {2'b0, resume_o, svc_o}, 4'b0010);
        step();
        chk("R12 run again", {3'b0, halted_o}, 4'd0);

        // idle2, serviceable pin
        mask_i = 0; halt_req = 1; mode_i = 2'b11; step(); idle_in();
        chk("R4 idle2 no window", {2'b0, halted_o, enter_o}, 4'b0010);
        chk("R3 idle2 gating", {1'b0, core_clk_en_o, periph_clk_en_o, osc_en_o}, 4'b0011);
        halt_req = 1; mode_i = 2'b01; step(); idle_in();
        chk("R11 halt ignored", {2'b0, osc_en_o, halted_o}, 4'b0011);
        pin_req = 1; pin_lvl = 5; step(); idle_in();
        chk("R8 pin serviced", {1'b0, svc_o, svc_src_o}, 4'b0101);
        step();

        // R7 nmi wakes under highest mask
        mask_i = 7; halt_req = 1; mode_i = 2'b11; step(); idle_in();
        nmi_req = 1; step(); idle_in();
        chk("R7 nmi mask7", {wake_o, svc_o, svc_src_o}, 4'b1110);
        step();

        // random phase against expectation state
        for (int n = 0; n < 4000; n++) begin
            halt_req = ($urandom_range(0, 7) == 0);
            mode_i   = 2'($urandom_range(0, 3));
            mask_i   = 3'($urandom_range(0, 7));
            mi_req   = ($urandom_range(0, 5) == 0);
            mi_lvl   = 3'($urandom_range(0, 7));
            pin_req  = ($urandom_range(0, 9) == 0);
            pin_lvl  = 3'($urandom_range(0, 7));
            nmi_req  = ($urandom_range(0, 19) == 0);
            step();
        end
        idle_in();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule